// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address. It does so by fetching descriptors from a two-level translation table held in ordinary memory. A client supplies the table's base address and a lookup request. The walker then fetches one descriptor per level, one 32-bit word at a time, over a simple memory read port. It ends with a single-cycle result. That result is either a done pulse with the physical address, or a fault pulse with the virtual address that could not be translated.

Three mapping granules are decoded. A first-level descriptor can describe a 1 MB section directly, or it can point to a 256-entry second-level table. A second-level descriptor describes either a 64 KB large page or a 4 KB small page. A large page is written into the table as 16 identical consecutive second-level descriptors, so any of the 16 slots yields the same frame. Results are not cached, and no permission checks are made.

The lookup request and the memory read request are valid/ready handshakes. The walker raises `req_ready` only while idle. A request held high while the walker is busy is back-pressured and stays pending until the walker returns to idle. A read request stays asserted, with its address unchanged, until the memory raises `rd_req_ready`. The read response has no back-pressure: the walker always accepts `rd_resp_valid` while it waits for a word. The result pins are plain single-cycle pulses with no handshake.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1 and `rd_req_valid`, `done` and `fault` are 0.
- R2: The first read goes to the table base plus four times virtual address bits [31:20].
- R3: A first-level descriptor whose low two bits are 2'b10 is a section. It completes after one read, with the physical address formed from descriptor bits [31:20] above virtual address bits [19:0].
- R4: A first-level descriptor whose low two bits are 2'b00 or 2'b11 raises `fault` after one read, with `fault_vaddr` equal to the request's virtual address.
- R5: A first-level descriptor whose low two bits are 2'b01 causes a second read. That read goes to (descriptor AND 32'hFFFFFC00) plus four times virtual address bits [19:12].
- R6: A second-level descriptor whose low two bits are 2'b00 raises `fault`, with `fault_vaddr` equal to the request's virtual address.
- R7: A second-level descriptor whose low two bits are 2'b01 is a large page. The physical address is descriptor bits [31:16] above virtual address bits [15:0]. Any of the 16 identical slots of a large page gives the same frame.
- R8: A second-level descriptor with bit 1 set (low bits 2'b10 or 2'b11) is a small page. The physical address is descriptor bits [31:12] above virtual address bits [11:0].
- R9: `done` and `fault` never rise together. Each is high for exactly one cycle, and the walker is idle in the next cycle.
- R10: A request is taken only when `req_ready` is 1, and `req_ready` is 1 only while idle. A request held during a walk is taken only after that walk's result pulse.
- R11: At most one read is outstanding. After a read is accepted, `rd_req_valid` stays low until the response arrives. A stalled read keeps `rd_req_valid` high and `rd_addr` stable.
- R12: `rd_resp_valid` arriving while no read is outstanding is ignored. No result pulse and no read follow from it.
- R13: The table base is sampled when the request is accepted. Later changes on `table_base` do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| table_base | input | 32 | Physical base address of the first-level table |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Word address of the descriptor to read |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Descriptor word returned by memory |
| done | output | 1 | One-cycle pulse: translation finished |
| paddr | output | 32 | Physical address, meaningful while `done` is 1 |
| fault | output | 1 | One-cycle pulse: translation fault |
| fault_vaddr | output | 32 | Faulting virtual address, meaningful while `fault` is 1 |

## Verification
Two pairs of events can land in the same cycle. The first pair is a result pulse and a new request. The bench holds a second request high through the whole of a first walk. It then checks that `req_ready` stays low up to and including the cycle of the first walk's `done`, that the second walk starts only afterwards, and that both results are correct. The second pair is a read response and an idle walker. The bench injects a response word that looks like a valid section while no read is outstanding. It then checks at the pins that no result pulse and no read follow, and that a normal walk afterwards is unaffected. Memory back-pressure and response latency are varied so that a stalled read must hold its address while no second read may start.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_ISSUE,
    S_L1_WAIT,
    S_L2_ISSUE,
    S_L2_WAIT,
    S_DONE,
    S_FAULT
  } walk_state_t;

  typedef enum logic [2:0] {
    K_FAULT,
    K_TABLE,
    K_SECT,
    K_LARGE,
    K_SMALL
  } desc_kind_t;

endpackage

// File: rtl/xw_slot_addr.sv
module xw_slot_addr #(
  parameter int AW    = 32,
  parameter int IDX_W = 12
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam int WORD_SHIFT = 2;

  // each descriptor is one 32-bit word
  assign addr = base + (AW'(idx) << WORD_SHIFT);
endmodule

// File: rtl/xw_desc_decode.sv
module xw_desc_decode import xw_pkg::*; #(
  parameter int LEVEL = 1
) (
  input  logic [1:0]  code,
  output desc_kind_t  kind
);
  generate
    if (LEVEL == 1) begin : g_first
      always_comb begin
        case (code)
          2'b01:   kind = K_TABLE;
          2'b10:   kind = K_SECT;
          default: kind = K_FAULT;
        endcase
      end
    end else begin : g_second
      always_comb begin
        if (code[1])      kind = K_SMALL;
        else if (code[0]) kind = K_LARGE;
        else              kind = K_FAULT;
      end
    end
  endgenerate
endmodule

// File: rtl/xw_paddr_build.sv
module xw_paddr_build import xw_pkg::*; #(
  parameter int AW          = 32,
  parameter int SECT_SHIFT  = 20,
  parameter int LARGE_SHIFT = 16,
  parameter int SMALL_SHIFT = 12
) (
  input  desc_kind_t    kind,
  input  logic [AW-1:0] entry,
  input  logic [AW-1:0] vaddr,
  output logic [AW-1:0] paddr
);
  localparam logic [AW-1:0] SECT_OFS  = (AW'(1) << SECT_SHIFT)  - AW'(1);
  localparam logic [AW-1:0] LARGE_OFS = (AW'(1) << LARGE_SHIFT) - AW'(1);
  localparam logic [AW-1:0] SMALL_OFS = (AW'(1) << SMALL_SHIFT) - AW'(1);

  always_comb begin
    case (kind)
      K_SECT:  paddr = (entry & ~SECT_OFS)  | (vaddr & SECT_OFS);
      K_LARGE: paddr = (entry & ~LARGE_OFS) | (vaddr & LARGE_OFS);
      K_SMALL: paddr = (entry & ~SMALL_OFS) | (vaddr & SMALL_OFS);
      default: paddr = '0;
    endcase
  end
endmodule

// File: rtl/xw_fsm.sv
module xw_fsm import xw_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rd_req_ready,
  input  logic        rd_resp_valid,
  input  desc_kind_t  kind_l1,
  input  desc_kind_t  kind_l2,
  output walk_state_t st
);
  walk_state_t nxt;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:     if (req_valid) nxt = S_L1_ISSUE;
      S_L1_ISSUE: if (rd_req_ready) nxt = S_L1_WAIT;
      S_L1_WAIT: begin
        if (rd_resp_valid) begin
          if (kind_l1 == K_SECT)       nxt = S_DONE;
          else if (kind_l1 == K_TABLE) nxt = S_L2_ISSUE;
          else                         nxt = S_FAULT;
        end
      end
      S_L2_ISSUE: if (rd_req_ready) nxt = S_L2_WAIT;
      S_L2_WAIT: begin
        if (rd_resp_valid) begin
          if (kind_l2 == K_LARGE || kind_l2 == K_SMALL) nxt = S_DONE;
          else                                          nxt = S_FAULT;
        end
      end
      S_DONE, S_FAULT: nxt = S_IDLE;
      default:         nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  // a request seen while idle starts the first-level fetch
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid) |=> (st == S_L1_ISSUE));

  // a stray response while idle leaves the walker idle
  assert_stray_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !req_valid && rd_resp_valid) |=> (st == S_IDLE));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker import xw_pkg::*; #(
  parameter int AW          = 32,
  parameter int SECT_SHIFT  = 20,
  parameter int LARGE_SHIFT = 16,
  parameter int SMALL_SHIFT = 12,
  parameter int L2_ALIGN    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] table_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_resp_valid,
  input  logic [AW-1:0] rd_resp_data,
  output logic          done,
  output logic [AW-1:0] paddr,
  output logic          fault,
  output logic [AW-1:0] fault_vaddr
);
  localparam int L1_IDX_W = AW - SECT_SHIFT;
  localparam int L2_IDX_W = SECT_SHIFT - SMALL_SHIFT;
  localparam logic [AW-1:0] L2_BASE_MASK = ~((AW'(1) << L2_ALIGN) - AW'(1));

  walk_state_t   st;
  desc_kind_t    kind_l1, kind_l2, kind_sel;
  logic [AW-1:0] vaddr_q, base_q, l2base_q, result_q;
  logic [AW-1:0] l1_addr, l2_addr, paddr_nxt;

  xw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_resp_valid (rd_resp_valid),
    .kind_l1       (kind_l1),
    .kind_l2       (kind_l2),
    .st            (st)
  );

  xw_slot_addr #(.AW(AW), .IDX_W(L1_IDX_W)) u_l1_addr (
    .base (base_q),
    .idx  (vaddr_q[AW-1:SECT_SHIFT]),
    .addr (l1_addr)
  );

  xw_slot_addr #(.AW(AW), .IDX_W(L2_IDX_W)) u_l2_addr (
    .base (l2base_q),
    .idx  (vaddr_q[SECT_SHIFT-1:SMALL_SHIFT]),
    .addr (l2_addr)
  );

  xw_desc_decode #(.LEVEL(1)) u_dec_l1 (.code(rd_resp_data[1:0]), .kind(kind_l1));
  xw_desc_decode #(.LEVEL(2)) u_dec_l2 (.code(rd_resp_data[1:0]), .kind(kind_l2));

  assign kind_sel = (st == S_L2_WAIT) ? kind_l2 : kind_l1;

  xw_paddr_build #(
    .AW(AW), .SECT_SHIFT(SECT_SHIFT), .LARGE_SHIFT(LARGE_SHIFT), .SMALL_SHIFT(SMALL_SHIFT)
  ) u_build (
    .kind  (kind_sel),
    .entry (rd_resp_data),
    .vaddr (vaddr_q),
    .paddr (paddr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q  <= '0;
      base_q   <= '0;
      l2base_q <= '0;
      result_q <= '0;
    end else begin
      if (st == S_IDLE && req_valid) begin
        vaddr_q <= req_vaddr;
        base_q  <= table_base;
      end
      if (st == S_L1_WAIT && rd_resp_valid) begin
        l2base_q <= rd_resp_data & L2_BASE_MASK;
        result_q <= paddr_nxt;
      end
      if (st == S_L2_WAIT && rd_resp_valid) begin
        result_q <= paddr_nxt;
      end
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign rd_req_valid = (st == S_L1_ISSUE) || (st == S_L2_ISSUE);
  assign rd_addr      = (st == S_L2_ISSUE) ? l2_addr : l1_addr;
  assign done         = (st == S_DONE);
  assign fault        = (st == S_FAULT);
  assign paddr        = result_q;
  assign fault_vaddr  = vaddr_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !fault && req_ready));

  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!fault && !done && req_ready));

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rd_req_valid && !done && !fault));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

  assert_hold_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] table_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_addr;
  logic        rd_resp_valid = 1'b0;
  logic [31:0] rd_resp_data = '0;
  logic        done;
  logic [31:0] paddr;
  logic        fault;
  logic [31:0] fault_vaddr;

  int n_cmp = 0;
  int n_bad = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:3];
  int          rd_n = 0;
  int          lat = 1;
  int          lat_cnt = 0;
  logic [31:0] pend_addr = '0;
  bit          stall = 1'b0;
  bit          inject = 1'b0;
  int          overlap = 0;
  int          cyc = 0;

  localparam logic [31:0] B1 = 32'h0010_0000;
  localparam logic [31:0] B2 = 32'h0800_0000;

  always #2 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .done(done), .paddr(paddr), .fault(fault), .fault_vaddr(fault_vaddr)
  );

  function automatic logic [31:0] memrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder, working between clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      rd_resp_valid = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt = lat_cnt - 1;
        if (lat_cnt == 0) begin
          rd_resp_valid = 1'b1;
          rd_resp_data  = memrd(pend_addr);
        end
      end
      if (inject) begin
        rd_resp_valid = 1'b1;
        rd_resp_data  = 32'h0000_0002;
        inject = 1'b0;
      end
      cyc = cyc + 1;
      rd_req_ready = stall ? ((cyc % 3) == 0) : 1'b1;
      if (rd_req_valid && lat_cnt != 0) overlap = overlap + 1;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_n < 4) rd_log[rd_n] = rd_addr;
        rd_n = rd_n + 1;
        pend_addr = rd_addr;
        lat_cnt = lat;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one translation; checks reads, result kind, result value and pulse width
  task automatic walk(input logic [31:0] va, input logic [31:0] b, input bit exp_fault,
                      input logic [31:0] exp_res, input int exp_reads,
                      input logic [31:0] a1, input logic [31:0] a2, input string tag);
    int t;
    @(negedge clk);
    rd_n = 0;
    table_base = b;
    req_vaddr = va;
    req_valid = 1'b1;
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    table_base = ~b;   // R13: must not matter after acceptance
    req_vaddr = 32'hFFFF_FFFF;
    t = 0;
    while (!(done || fault) && t < 200) begin @(negedge clk); t++; end
    chk({tag, " result seen"}, 32'(done || fault), 32'd1);
    chk({tag, " fault flag"}, 32'(fault), 32'(exp_fault));
    chk({tag, " R9 exclusive"}, 32'(done && fault), 32'd0);
    if (exp_fault) chk({tag, " fault address"}, fault_vaddr, exp_res);
    else           chk({tag, " physical address"}, paddr, exp_res);
    chk({tag, " read count"}, 32'(rd_n), 32'(exp_reads));
    chk({tag, " R2 first read address"}, rd_log[0], a1);
    if (exp_reads == 2) chk({tag, " R5 second read address"}, rd_log[1], a2);
    @(negedge clk);
    chk({tag, " R9 pulse ends, idle"}, {30'd0, done || fault, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rd_req_valid", 32'(rd_req_valid), 32'd0);
    chk("R1 done/fault", 32'(done || fault), 32'd0);
  endtask

  task automatic t_section();
    walk(32'h1234_5678, B1, 1'b0, 32'hABC4_5678, 1, 32'h0010_048C, 32'h0, "R3 section");
    walk(32'h1234_5678, B2, 1'b0, 32'h0DE4_5678, 1, 32'h0800_048C, 32'h0, "R13 other base");
  endtask

  task automatic t_l1_fault();
    walk(32'h2000_0000, B1, 1'b1, 32'h2000_0000, 1, 32'h0010_0800, 32'h0, "R4 code00");
    walk(32'h3010_0000, B1, 1'b1, 32'h3010_0000, 1, 32'h0010_0C04, 32'h0, "R4 code11");
  endtask

  task automatic t_small();
    walk(32'h4005_6ABC, B1, 1'b0, 32'h8765_4ABC, 2, 32'h0010_1000, 32'h0020_0558, "R8 small10");
    walk(32'h4005_7123, B1, 1'b0, 32'h1111_1123, 2, 32'h0010_1000, 32'h0020_055C, "R8 small11");
  endtask

  task automatic t_large();
    walk(32'h4013_4567, B1, 1'b0, 32'h5550_4567, 2, 32'h0010_1004, 32'h0030_00D0, "R7 large");
    walk(32'h4013_FFFE, B1, 1'b0, 32'h5550_FFFE, 2, 32'h0010_1004, 32'h0030_00FC, "R7 last slot");
  endtask

  task automatic t_l2_fault();
    walk(32'h4018_0000, B1, 1'b1, 32'h4018_0000, 2, 32'h0010_1004, 32'h0030_0200, "R6 l2 fault");
  endtask

  task automatic t_stall();
    stall = 1'b1;
    lat = 3;
    overlap = 0;
    walk(32'h4005_6ABC, B1, 1'b0, 32'h8765_4ABC, 2, 32'h0010_1000, 32'h0020_0558, "R11 stalled");
    chk("R11 no second read outstanding", 32'(overlap), 32'd0);
    stall = 1'b0;
    lat = 1;
  endtask

  task automatic t_stray();
    int bad;
    bad = 0;
    @(negedge clk);
    rd_n = 0;
    inject = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done || fault || rd_req_valid || !req_ready) bad++;
    end
    chk("R12 stray response ignored", 32'(bad), 32'd0);
    chk("R12 no read issued", 32'(rd_n), 32'd0);
    walk(32'h1234_5678, B1, 1'b0, 32'hABC4_5678, 1, 32'h0010_048C, 32'h0, "R12 walk after");
  endtask

  task automatic t_back_to_back();
    int t;
    int early;
    @(negedge clk);
    table_base = B1;
    req_vaddr = 32'h1234_5678;
    req_valid = 1'b1;
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_vaddr = 32'h4005_6ABC;   // held high while busy
    early = 0;
    t = 0;
    while (!(done || fault) && t < 200) begin
      if (req_ready) early++;
      @(negedge clk); t++;
    end
    if (req_ready) early++;
    chk("R10 first result", paddr, 32'hABC4_5678);
    chk("R10 no acceptance while busy", 32'(early), 32'd0);
    @(negedge clk);
    chk("R10 idle after pulse", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!(done || fault) && t < 200) begin @(negedge clk); t++; end
    chk("R10 second result", paddr, 32'h8765_4ABC);
    chk("R10 second is done", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mem[32'h0010_048C] = 32'hABC0_0002;
    mem[32'h0010_0C04] = 32'hFFFF_FFFF;
    mem[32'h0010_1000] = 32'h0020_07F1;
    mem[32'h0020_0558] = 32'h8765_4002;
    mem[32'h0020_055C] = 32'h1111_1FFF;
    mem[32'h0010_1004] = 32'h0030_0001;
    mem[32'h0800_048C] = 32'h0DE0_0002;
    for (int i = 0; i < 16; i++) mem[32'h0030_00C0 + 32'(4 * i)] = 32'h5550_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section();
    t_l1_fault();
    t_small();
    t_large();
    t_l2_fault();
    t_stall();
    t_stray();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule